// File: doc/BRIEF.md
# Masked GPIO Port with Edge Interrupts

This block is a general-purpose I/O port of `WIDTH` pins (32 by default) that software controls over a simple single-cycle register bus. Each pin has a direction bit that turns its output driver on or off and an output latch that is changed through set-only, clear-only or full-value writes. A per-pin access mask protects selected pins from all three kinds of write and hides them in pin-level reads.

Pin inputs pass through a two-flop synchronizer. The synchronized levels are compared with their values one cycle earlier to find rising and falling transitions. Each direction of transition has its own per-pin enable and its own sticky per-pin status register. A write-one-to-clear register drops pending status bits. One combined interrupt line, also readable as a one-bit register, is raised while any status bit is pending.

Top module: `gpio_edge_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `pin_oe`, `pin_out` and `irq` are 0, and the direction, mask, enable and status registers all read 0. Every pin is therefore an input after reset.
- R2: Writing the direction register (word index 0) sets `pin_oe` to the written value at the write edge. A 1 bit makes the pin an output and a 0 bit makes it an input. `pin_out` always shows the output latch.
- R3: A 1 in the mask register (word index 1) protects that pin. Writes to the set, clear and level registers leave its latch bit unchanged, and a read of the level register returns 0 for it. A 0 in the mask leaves the pin accessible.
- R4: Writing the set register (word index 3) drives each unmasked pin whose data bit is 1 to high and leaves every other latch bit unchanged. Reading index 3 returns the output latch.
- R5: Writing the clear register (word index 4) drives each unmasked pin whose data bit is 1 to low and leaves every other latch bit unchanged. Reading index 4 returns the output latch.
- R6: Writing the level register (word index 2) copies the written data into the latch bits of unmasked pins only. A read of index 2 returns the synchronized input levels with masked bits at 0. A change on `pin_in` shows in this read after the second rising clock edge, and not after the first.
- R7: The rising-enable (index 5) and falling-enable (index 6) registers select which pins may latch a rising status bit (index 7) or a falling status bit (index 8). A transition sets its status bit at the third rising edge after the `pin_in` change. A transition on a pin whose enable for that direction is 0 sets nothing. The mask has no effect on interrupts.
- R8: Writing 1 to a bit of the interrupt-clear register (index 9) clears both the rising and the falling status of that pin, and a 0 bit leaves them unchanged. If an enabled transition is detected in the same cycle as the clear, the status bit ends up set.
- R9: `irq` is high exactly when any rising or falling status bit is set. Bit 0 of index 10 reads the same value, and its other bits read 0.
- R10: Writes take effect at the rising edge where `bus_wr_en` is high. `bus_rdata` follows `bus_addr` combinationally. Index 9 and the unmapped indices 11 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined edge interrupt |

## Verification
Register writes show on `pin_oe`, `pin_out` and in readback after the write edge, so the bench drives each write at a falling edge, holds it through one rising edge and checks at the next falling edge. A pin change shows in the level read after two rising edges, and the bench reads at both one and two edges to catch a stage that is missing or extra. Status bits and `irq` are due at the third rising edge. The bench checks that they are still low after the second edge and correct after the third, and it times a clear write to land on that same third edge to test which of the two wins.

// File: rtl/gpio_edge_pkg.sv
// Package gpio_edge_pkg
// Register word indices and bus widths shared by the GPIO port modules.
// Assumes a word-indexed bus where each register occupies one index.
package gpio_edge_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        IDX_DIR     = 4'd0,
        IDX_MASK    = 4'd1,
        IDX_LEVEL   = 4'd2,
        IDX_SET     = 4'd3,
        IDX_CLR     = 4'd4,
        IDX_RISE_EN = 4'd5,
        IDX_FALL_EN = 4'd6,
        IDX_RISE_ST = 4'd7,
        IDX_FALL_ST = 4'd8,
        IDX_INT_CLR = 4'd9,
        IDX_ANY_ST  = 4'd10
    } reg_idx_e;

endpackage

// File: rtl/gpio_ctrl_regs.sv
// Module gpio_ctrl_regs
// Holds the direction, mask, output latch and edge-enable registers and
// applies masked set, clear and full-value writes to the output latch.
// Assumes single-cycle writes; the mask in force is the value held before
// the write edge.
module gpio_ctrl_regs
    import gpio_edge_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  mask_q,
    output logic [WIDTH-1:0]  out_q,
    output logic [WIDTH-1:0]  rise_en_q,
    output logic [WIDTH-1:0]  fall_en_q
);

    logic [WIDTH-1:0] open_bits;
    logic [WIDTH-1:0] out_d;
    logic             wr_dir, wr_mask, wr_level, wr_set, wr_clr;
    logic             wr_ren, wr_fen;

    // Decode one write strobe per register.
    always_comb begin
        wr_dir   = wr_en && (addr == IDX_DIR);
        wr_mask  = wr_en && (addr == IDX_MASK);
        wr_level = wr_en && (addr == IDX_LEVEL);
        wr_set   = wr_en && (addr == IDX_SET);
        wr_clr   = wr_en && (addr == IDX_CLR);
        wr_ren   = wr_en && (addr == IDX_RISE_EN);
        wr_fen   = wr_en && (addr == IDX_FALL_EN);
    end

    // Written bits that are allowed through the mask.
    assign open_bits = wdata & ~mask_q;

    // Next value of the output latch for the three write styles.
    always_comb begin
        out_d = out_q;
        if (wr_set) begin
            out_d = out_q | open_bits;
        end else if (wr_clr) begin
            out_d = out_q & ~open_bits;
        end else if (wr_level) begin
            out_d = (out_q & mask_q) | open_bits;
        end
    end

    // Configuration registers, cleared so that every pin starts as an input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= '0;
            mask_q    <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else begin
            if (wr_dir)  dir_q     <= wdata;
            if (wr_mask) mask_q    <= wdata;
            if (wr_ren)  rise_en_q <= wdata;
            if (wr_fen)  fall_en_q <= wdata;
        end
    end

    // Output latch.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    AST_RESET_INPUTS: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '0) && (out_q == '0)); // R1

    AST_DIR_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> dir_q == $past(wdata)); // R2

    AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set || wr_clr || wr_level) |=>
            ((out_q & $past(mask_q)) == ($past(out_q) & $past(mask_q)))); // R3

    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((out_q & $past(open_bits)) == $past(open_bits))); // R4

    AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((out_q & $past(open_bits)) == '0)); // R5

endmodule

// File: rtl/gpio_edge_detect.sv
// Module gpio_edge_detect
// Brings asynchronous pin levels into the clock domain through a chain of
// SYNC_STAGES flops, then flags rising and falling transitions by comparing
// the synchronized level with its value one cycle earlier.
// Assumes pins change slower than the clock.
module gpio_edge_detect #(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] level_q,
    output logic [WIDTH-1:0] rise_pulse,
    output logic [WIDTH-1:0] fall_pulse
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [WIDTH-1:0] chain_q [SYNC_STAGES];
    logic [WIDTH-1:0] prev_q;

    // First synchronizer stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= pin_in;
    end

    generate
        for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
            // Further synchronizer stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    // Synchronized level one cycle ago, for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[LAST];
    end

    assign level_q    = chain_q[LAST];
    assign rise_pulse = chain_q[LAST] & ~prev_q;
    assign fall_pulse = ~chain_q[LAST] & prev_q;

endmodule

// File: rtl/gpio_irq_status.sv
// Module gpio_irq_status
// Sticky rising and falling status registers fed by enabled transitions,
// cleared per pin by a write-one-to-clear strobe; a new transition in the
// clearing cycle keeps its bit set. Drives the combined interrupt.
// Assumes transition pulses last one cycle.
module gpio_irq_status #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rise_pulse,
    input  logic [WIDTH-1:0] fall_pulse,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic             clr_wr,
    input  logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] rise_st_q,
    output logic [WIDTH-1:0] fall_st_q,
    output logic             irq
);

    logic [WIDTH-1:0] rise_evt, fall_evt, drop;

    // Qualify transitions with their enables and form the clear vector.
    always_comb begin
        rise_evt = rise_pulse & rise_en;
        fall_evt = fall_pulse & fall_en;
        drop     = clr_wr ? clr_bits : '0;
    end

    // Sticky status; a same-cycle event overrides the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_st_q <= '0;
            fall_st_q <= '0;
        end else begin
            rise_st_q <= (rise_st_q & ~drop) | rise_evt;
            fall_st_q <= (fall_st_q & ~drop) | fall_evt;
        end
    end

    // Combined interrupt.
    assign irq = |{rise_st_q, fall_st_q};

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !irq); // R1

    AST_ONLY_ENABLED_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rise_st_q & ~$past(rise_st_q) & ~$past(rise_en)) == '0)); // R7

    AST_ONLY_ENABLED_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fall_st_q & ~$past(fall_st_q) & ~$past(fall_en)) == '0)); // R7

    AST_NEW_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_evt != '0) |=> ((rise_st_q & $past(rise_evt)) == $past(rise_evt))); // R8

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((fall_st_q & $past(clr_bits & ~fall_evt)) == '0)); // R8

endmodule

// File: rtl/gpio_edge_port.sv
// Module gpio_edge_port
// Top of the masked GPIO port: ties the control registers, the input
// synchronizer with transition detection and the interrupt status together
// and provides the combinational read multiplexer.
// Assumes WIDTH of at most 32 so that every register fits one bus word.
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              irq
);

    logic [WIDTH-1:0] dir_q, mask_q, out_q, rise_en_q, fall_en_q;
    logic [WIDTH-1:0] level_q, rise_pulse, fall_pulse;
    logic [WIDTH-1:0] rise_st_q, fall_st_q;
    logic             irq_w;
    logic             clr_wr;

    gpio_ctrl_regs #(.WIDTH(WIDTH)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr_en),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .dir_q     (dir_q),
        .mask_q    (mask_q),
        .out_q     (out_q),
        .rise_en_q (rise_en_q),
        .fall_en_q (fall_en_q)
    );

    gpio_edge_detect #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .level_q    (level_q),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse)
    );

    assign clr_wr = bus_wr_en && (bus_addr == IDX_INT_CLR);

    gpio_irq_status #(.WIDTH(WIDTH)) i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse),
        .rise_en    (rise_en_q),
        .fall_en    (fall_en_q),
        .clr_wr     (clr_wr),
        .clr_bits   (bus_wdata),
        .rise_st_q  (rise_st_q),
        .fall_st_q  (fall_st_q),
        .irq        (irq_w)
    );

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = irq_w;

    // Read multiplexer; masked pins read 0 in the level view.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            IDX_DIR:     bus_rdata = dir_q;
            IDX_MASK:    bus_rdata = mask_q;
            IDX_LEVEL:   bus_rdata = level_q & ~mask_q;
            IDX_SET:     bus_rdata = out_q;
            IDX_CLR:     bus_rdata = out_q;
            IDX_RISE_EN: bus_rdata = rise_en_q;
            IDX_FALL_EN: bus_rdata = fall_en_q;
            IDX_RISE_ST: bus_rdata = rise_st_q;
            IDX_FALL_ST: bus_rdata = fall_st_q;
            IDX_ANY_ST:  bus_rdata[0] = irq_w;
            default:     bus_rdata = '0;
        endcase
    end

    AST_IRQ_NEEDS_PRIOR_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(rise_pulse | fall_pulse) != '0); // R9

endmodule

// File: tb/test_gpio_edge_port.sv
module test_gpio_edge_port;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pin_in = '0;
    logic [W-1:0]  pin_out;
    logic [W-1:0]  pin_oe;
    logic          irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    gpio_edge_port i_gpio_edge_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    function automatic logic [31:0] nxt(input logic [31:0] x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] r, seed, latch, mask, d, a, b, ren, fen, er, ef, c, prev_in;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 pin_oe in reset", pin_oe, 0);
        chk("R1 irq in reset", {31'd0, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 pin_out", pin_out, 0);
        rd(4'd0, r);  chk("R1 dir", r, 0);
        rd(4'd1, r);  chk("R1 mask", r, 0);
        rd(4'd5, r);  chk("R1 rise_en", r, 0);
        rd(4'd7, r);  chk("R1 rise_st", r, 0);
        rd(4'd8, r);  chk("R1 fall_st", r, 0);

        // R2: walk every direction bit, then its complement
        for (int i = 0; i < W; i++) begin
            wr(4'd0, 32'd1 << i);
            chk("R2 pin_oe walk", pin_oe, 32'd1 << i);
            wr(4'd0, ~(32'd1 << i));
            rd(4'd0, r);
            chk("R2 dir readback", r, ~(32'd1 << i));
        end

        // R3 R4 R5 R6: masked set, clear and level writes
        seed  = 32'h1234_5678;
        latch = '0;
        for (int k = 0; k < 40; k++) begin
            seed = nxt(seed); mask = seed;
            wr(4'd1, mask);
            seed = nxt(seed); d = seed;
            wr(4'd3, d);
            latch = latch | (d & ~mask);
            chk("R4 set under mask R3", pin_out, latch);
            seed = nxt(seed); d = seed;
            wr(4'd4, d);
            latch = latch & ~(d & ~mask);
            chk("R5 clear under mask R3", pin_out, latch);
            rd(4'd4, r);
            chk("R5 latch readback", r, latch);
            seed = nxt(seed); d = seed;
            wr(4'd2, d);
            latch = (latch & mask) | (d & ~mask);
            chk("R6 level write under mask R3", pin_out, latch);
            rd(4'd3, r);
            chk("R4 latch readback", r, latch);
        end
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd4, 32'hFFFF_FFFF);
        chk("R3 fully masked latch held", pin_out, latch);

        // R6: level read latency and masking
        prev_in = pin_in;
        for (int k = 0; k < 24; k++) begin
            seed = nxt(seed); mask = (k < 4) ? 32'd0 : seed;
            wr(4'd1, mask);
            seed = nxt(seed);
            @(negedge clk);
            pin_in = seed;
            @(negedge clk);
            rd(4'd2, r);
            chk("R6 level after one edge", r, prev_in & ~mask);
            @(negedge clk);
            rd(4'd2, r);
            chk("R6 level after two edges R3", r, seed & ~mask);
            prev_in = seed;
        end

        // R7 R8 R9: edge status timing, enables, partial clear
        wr(4'd1, 32'h0000_FFFF); // mask must not affect interrupts
        for (int k = 0; k < 40; k++) begin
            seed = nxt(seed); ren = (k == 0) ? 32'd0 : seed;
            seed = nxt(seed); fen = (k == 1) ? 32'd0 : seed;
            wr(4'd5, ren);
            wr(4'd6, fen);
            seed = nxt(seed); a = seed;
            @(negedge clk); pin_in = a;
            repeat (3) @(negedge clk);
            wr(4'd9, 32'hFFFF_FFFF);
            chk("R8 full clear irq", {31'd0, irq}, 0);
            seed = nxt(seed); b = a ^ seed;
            @(negedge clk); pin_in = b;
            er = ~a & b & ren;
            ef = a & ~b & fen;
            @(negedge clk);
            @(negedge clk);
            chk("R7 no status after two edges", {31'd0, irq}, 0);
            @(negedge clk);
            rd(4'd7, r);  chk("R7 rise status", r, er);
            rd(4'd8, r);  chk("R7 fall status", r, ef);
            chk("R9 irq", {31'd0, irq}, {31'd0, |(er | ef)});
            rd(4'd10, r); chk("R9 any status", r, {31'd0, |(er | ef)});
            seed = nxt(seed); c = seed;
            wr(4'd9, c);
            rd(4'd7, r);  chk("R8 partial clear rise", r, er & ~c);
            rd(4'd8, r);  chk("R8 partial clear fall", r, ef & ~c);
            chk("R9 irq after clear", {31'd0, irq}, {31'd0, |((er | ef) & ~c)});
        end

        // R8: new edge in the clearing cycle wins
        wr(4'd5, 32'h0000_0001);
        wr(4'd6, 32'h0000_0000);
        @(negedge clk); pin_in = 32'h0;
        repeat (3) @(negedge clk);
        wr(4'd9, 32'hFFFF_FFFF);
        @(negedge clk); pin_in = 32'h1;
        @(negedge clk);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 4'd9; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0;
        rd(4'd7, r);
        chk("R8 edge beats clear", r, 32'h1);
        chk("R9 irq kept", {31'd0, irq}, 1);

        // R10: unmapped and write-only indices read 0
        rd(4'd9, r);  chk("R10 int clear reads 0", r, 0);
        for (int u = 11; u < 16; u++) begin
            rd(u[3:0], r);
            chk("R10 unmapped", r, 0);
        end

        // R1: reset again returns to inputs
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 second reset oe", pin_oe, 0);
        chk("R1 second reset irq", {31'd0, irq}, 0);

        finish_run();
    end

endmodule